// File: doc/BRIEF.md
# Programmable GPIO with Interrupt and Wake

The block controls eight general-purpose lines. Each line has a direction bit and an output value. An inversion bit flips the line's input sense. The adjusted level of each line can be read back. Software reaches all of this through a byte-wide register port addressed by an 8-bit offset. Reads have no side effects. Writes take effect on the next rising clock edge.

Two masks pick the lines that take part in events. The first mask selects the input lines whose adjusted level drives an active-low host interrupt. The second mask selects the input lines that raise a wake request. The wake output is open-drain: an enable plus a constant low value. It can be asserted only while the wake-enable input is high, so an external event such as a ring can switch the system on.

A select bit hands the two top lines to the device power-state field, so that the current state can be shown at the pins. Pin inputs pass through a synchronizer before any logic uses them.

Top module: `gpio_wake_ctrl`

## Requirements
- R1: After reset every register reads 0, pin_oe_o is 0, irq_n_o is 1 and wake_oe_o is 0.
- R2: Offset 0x02 is the direction register. A 1 in bit i makes line i an output. pin_oe_o equals the register from the edge that writes it, and the register reads back at 0x02.
- R3: Offset 0x03 is the output value register. pin_o[i] equals its bit i, except for the lines replaced under R8. It reads back at 0x03.
- R4: Offset 0x07 is the read-only status register. It returns pin_i XOR polarity, with pin_i delayed by two synchronizer edges. Writes to 0x07 change no register.
- R5: Offset 0x2A is the polarity register. A 1 in bit i inverts line i's input level everywhere: status, interrupt and wake.
- R6: Offset 0x05 is the interrupt mask. irq_n_o is 0 exactly when some line i has mask bit 1, direction 0 and adjusted level 1. This output is registered one edge after the status value.
- R7: Offset 0x29 is the wake mask. wake_oe_o is 1 exactly when wake_en_i is 1 and some line i has wake-mask bit 1, direction 0 and adjusted level 1. This output is registered with the same timing as irq_n_o. wake_o is always 0.
- R8: Offset 0x2B bit 0 is the power-state select. When it is 1, pin_o[6] carries pwr_state_i[0] and pin_o[7] carries pwr_state_i[1]. Bits 7:1 of 0x2B read as 0.
- R9: Offsets other than 0x02, 0x03, 0x05, 0x07, 0x29, 0x2A and 0x2B read as 0, and writes to them change no register or output.
- R10: Lines with direction 1 never contribute to irq_n_o or wake_oe_o, whatever their level and mask bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| pin_i | input | 8 | Line input levels from the pads |
| pin_o | output | 8 | Line output values |
| pin_oe_o | output | 8 | Line output enables |
| pwr_state_i | input | 2 | Device power-state field |
| wake_en_i | input | 1 | Wake output permission |
| irq_n_o | output | 1 | Host interrupt, active low |
| wake_oe_o | output | 1 | Wake request: open-drain drive enable |
| wake_o | output | 1 | Wake output value, constant 0 |

## Verification
Register writes are driven across one rising edge. pin_o, pin_oe_o and read data are then sampled at the next falling edge, because they follow the register contents without further delay.

A pin change applied at a falling edge reaches the status readback after two rising edges. It reaches irq_n_o and wake_oe_o after three. The bench therefore waits exactly three edges before it samples all three results.

A change on wake_en_i or on a mask register appears on the event outputs one edge later. A change on pwr_state_i appears on pin_o at once, so both are sampled at the following falling edge. Expected values are computed arithmetically from shadow copies of the registers while the pin value is swept over all 256 patterns under several configurations.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;

    localparam logic [7:0] OFF_DIR    = 8'h02;
    localparam logic [7:0] OFF_DOUT   = 8'h03;
    localparam logic [7:0] OFF_IMASK  = 8'h05;
    localparam logic [7:0] OFF_STATUS = 8'h07;
    localparam logic [7:0] OFF_WMASK  = 8'h29;
    localparam logic [7:0] OFF_POL    = 8'h2A;
    localparam logic [7:0] OFF_PSEL   = 8'h2B;

    function automatic logic off_mapped(input logic [7:0] a);
        return (a == OFF_DIR) || (a == OFF_DOUT) || (a == OFF_IMASK) ||
               (a == OFF_STATUS) || (a == OFF_WMASK) || (a == OFF_POL) ||
               (a == OFF_PSEL);
    endfunction

endpackage

// File: rtl/gpio_insync.sv
module gpio_insync #(
    parameter int unsigned NUM_LINES   = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] async_i,
    output logic [NUM_LINES-1:0] sync_o
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [NUM_LINES-1:0] stage_d [SYNC_STAGES];
    logic [NUM_LINES-1:0] stage_q [SYNC_STAGES];

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = async_i;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_wake_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [7:0]           addr_i,
    input  logic [NUM_LINES-1:0] wdata_i,
    input  logic [NUM_LINES-1:0] status_i,
    output logic [NUM_LINES-1:0] rdata_o,
    output logic [NUM_LINES-1:0] dir_o,
    output logic [NUM_LINES-1:0] dout_o,
    output logic [NUM_LINES-1:0] imask_o,
    output logic [NUM_LINES-1:0] wmask_o,
    output logic [NUM_LINES-1:0] pol_o,
    output logic                 psel_o
);
    typedef struct packed {
        logic [NUM_LINES-1:0] dir;
        logic [NUM_LINES-1:0] dout;
        logic [NUM_LINES-1:0] imask;
        logic [NUM_LINES-1:0] wmask;
        logic [NUM_LINES-1:0] pol;
        logic                 psel;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_i) begin
            unique case (addr_i)
                OFF_DIR:   regs_d.dir   = wdata_i;
                OFF_DOUT:  regs_d.dout  = wdata_i;
                OFF_IMASK: regs_d.imask = wdata_i;
                OFF_WMASK: regs_d.wmask = wdata_i;
                OFF_POL:   regs_d.pol   = wdata_i;
                OFF_PSEL:  regs_d.psel  = wdata_i[0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFF_DIR:    rdata_o = regs_q.dir;
            OFF_DOUT:   rdata_o = regs_q.dout;
            OFF_IMASK:  rdata_o = regs_q.imask;
            OFF_STATUS: rdata_o = status_i;
            OFF_WMASK:  rdata_o = regs_q.wmask;
            OFF_POL:    rdata_o = regs_q.pol;
            OFF_PSEL:   rdata_o = {{(NUM_LINES-1){1'b0}}, regs_q.psel};
            default:    rdata_o = '0;
        endcase
    end

    assign dir_o   = regs_q.dir;
    assign dout_o  = regs_q.dout;
    assign imask_o = regs_q.imask;
    assign wmask_o = regs_q.wmask;
    assign pol_o   = regs_q.pol;
    assign psel_o  = regs_q.psel;

    AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFF_STATUS) |=> $stable(regs_q)); // R4

    AST_UNMAPPED_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !off_mapped(addr_i)) |=> $stable(regs_q)); // R9

    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!off_mapped(addr_i)) |-> (rdata_o == '0)); // R9

endmodule

// File: rtl/gpio_event.sv
module gpio_event #(
    parameter int unsigned NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] level_i,
    input  logic [NUM_LINES-1:0] dir_i,
    input  logic [NUM_LINES-1:0] imask_i,
    input  logic [NUM_LINES-1:0] wmask_i,
    input  logic                 wake_en_i,
    output logic                 irq_n_o,
    output logic                 wake_oe_o
);
    typedef struct packed {
        logic irq_n;
        logic wake_oe;
    } evt_t;

    evt_t evt_d, evt_q;
    logic [NUM_LINES-1:0] in_active;

    always_comb begin
        in_active     = level_i & ~dir_i;
        evt_d.irq_n   = ~|(in_active & imask_i);
        evt_d.wake_oe = wake_en_i & (|(in_active & wmask_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '{irq_n: 1'b1, wake_oe: 1'b0};
        else        evt_q <= evt_d;
    end

    assign irq_n_o   = evt_q.irq_n;
    assign wake_oe_o = evt_q.wake_oe;

    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_en_i) |=> (!wake_oe_o)); // R7

    AST_OUTPUT_LINES_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (&dir_i) |=> (irq_n_o && !wake_oe_o)); // R10

    AST_NO_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (imask_i == '0) |=> irq_n_o); // R6

endmodule

// File: rtl/gpio_wake_ctrl.sv
module gpio_wake_ctrl
    import gpio_wake_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_i,
    input  logic [7:0]           reg_addr_i,
    input  logic [NUM_LINES-1:0] reg_wdata_i,
    output logic [NUM_LINES-1:0] reg_rdata_o,
    input  logic [NUM_LINES-1:0] pin_i,
    output logic [NUM_LINES-1:0] pin_o,
    output logic [NUM_LINES-1:0] pin_oe_o,
    input  logic [1:0]           pwr_state_i,
    input  logic                 wake_en_i,
    output logic                 irq_n_o,
    output logic                 wake_oe_o,
    output logic                 wake_o
);
    localparam int unsigned PS_HI = NUM_LINES - 1;
    localparam int unsigned PS_LO = NUM_LINES - 2;

    logic [NUM_LINES-1:0] pin_sync;
    logic [NUM_LINES-1:0] level_adj;
    logic [NUM_LINES-1:0] dir, dout, imask, wmask, pol;
    logic                 psel;

    gpio_insync #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    assign level_adj = pin_sync ^ pol;

    gpio_regfile #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .status_i (level_adj),
        .rdata_o  (reg_rdata_o),
        .dir_o    (dir),
        .dout_o   (dout),
        .imask_o  (imask),
        .wmask_o  (wmask),
        .pol_o    (pol),
        .psel_o   (psel)
    );

    gpio_event #(.NUM_LINES(NUM_LINES)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (level_adj),
        .dir_i     (dir),
        .imask_i   (imask),
        .wmask_i   (wmask),
        .wake_en_i (wake_en_i),
        .irq_n_o   (irq_n_o),
        .wake_oe_o (wake_oe_o)
    );

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_out
            if (i == PS_HI) begin : g_ps_hi
                assign pin_o[i] = psel ? pwr_state_i[1] : dout[i];
            end else if (i == PS_LO) begin : g_ps_lo
                assign pin_o[i] = psel ? pwr_state_i[0] : dout[i];
            end else begin : g_plain
                assign pin_o[i] = dout[i];
            end
        end
    endgenerate

    assign pin_oe_o = dir;
    assign wake_o   = 1'b0;

    AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == OFF_DIR) |=> (pin_oe_o == $past(reg_wdata_i))); // R2

    AST_PS_ON_TOP_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == OFF_PSEL && reg_wdata_i[0])
        |=> (pin_o[PS_HI:PS_LO] == pwr_state_i)); // R8

    AST_WAKE_VALUE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wake_oe_o |-> !wake_o); // R7

endmodule

// File: tb/gpio_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_wake_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out, pin_oe;
    logic [1:0] pwr_state = 2'b00;
    logic       wake_en = 1'b0;
    logic       irq_n, wake_oe, wake_val;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_wake_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .pin_i       (pin_in),
        .pin_o       (pin_out),
        .pin_oe_o    (pin_oe),
        .pwr_state_i (pwr_state),
        .wake_en_i   (wake_en),
        .irq_n_o     (irq_n),
        .wake_oe_o   (wake_oe),
        .wake_o      (wake_val)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic read_check(input string tag, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #0.5;
        check(tag, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    logic [7:0] s_dir, s_dout, s_imask, s_wmask, s_pol;
    logic       s_psel;

    task automatic set_cfg(input logic [7:0] d, input logic [7:0] p, input logic [7:0] im,
                           input logic [7:0] wm);
        do_write(8'h02, d);  s_dir = d;
        do_write(8'h2A, p);  s_pol = p;
        do_write(8'h05, im); s_imask = im;
        do_write(8'h29, wm); s_wmask = wm;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    logic [7:0] cd [4] = '{8'h00, 8'h0F, 8'h00, 8'hA5};
    logic [7:0] cp [4] = '{8'h00, 8'h00, 8'hFF, 8'h3C};
    logic [7:0] ci [4] = '{8'hFF, 8'hF0, 8'h01, 8'hFF};
    logic [7:0] cw [4] = '{8'h00, 8'hFF, 8'h80, 8'h5A};
    logic       ce [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
    logic [7:0] dpat [5] = '{8'h55, 8'hAA, 8'h00, 8'hFF, 8'h81};
    logic [7:0] junk [6] = '{8'h00, 8'h01, 8'h07, 8'h10, 8'hFF, 8'h2C};

    initial begin
        s_dir = 0; s_dout = 0; s_imask = 0; s_wmask = 0; s_pol = 0; s_psel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
        check("R1 irq_n", {31'h0, irq_n}, 32'h1);
        check("R1 wake_oe", {31'h0, wake_oe}, 32'h0);
        for (int a = 0; a < 256; a++) read_check("R1 reg zero", a[7:0], 8'h00);

        // R2 / R3: direction and output values
        for (int k = 0; k < 5; k++) begin
            do_write(8'h02, ~dpat[k]);
            do_write(8'h03, dpat[k]);
            check("R2 pin_oe", {24'h0, pin_oe}, {24'h0, ~dpat[k]});
            check("R3 pin_o", {24'h0, pin_out}, {24'h0, dpat[k]});
            read_check("R2 dir readback", 8'h02, ~dpat[k]);
            read_check("R3 dout readback", 8'h03, dpat[k]);
        end
        s_dir = ~dpat[4]; s_dout = dpat[4];

        // R8: power-state override of the top two lines
        do_write(8'h03, 8'hFF); s_dout = 8'hFF;
        do_write(8'h2B, 8'hFF); s_psel = 1'b1;
        read_check("R8 psel readback", 8'h2B, 8'h01);
        for (int ps = 0; ps < 4; ps++) begin
            @(negedge clk);
            pwr_state = ps[1:0];
            #0.5;
            check("R8 pin_o override", {24'h0, pin_out}, {24'h0, ps[1:0], 6'h3F});
        end
        do_write(8'h2B, 8'h00); s_psel = 1'b0;
        check("R8 pin_o released", {24'h0, pin_out}, 32'hFF);

        // R9: unmapped and read-only offsets ignore writes
        for (int j = 0; j < 6; j++) begin
            do_write(junk[j], 8'h5A);
            read_check("R9 dir intact", 8'h02, s_dir);
            read_check("R9 dout intact", 8'h03, s_dout);
            read_check("R9 imask intact", 8'h05, s_imask);
            read_check("R9 wmask intact", 8'h29, s_wmask);
            read_check("R9 pol intact", 8'h2A, s_pol);
            read_check("R9 psel intact", 8'h2B, 8'h00);
            read_check("R9 unmapped zero", junk[j], (junk[j] == 8'h07) ? 8'h00 : 8'h00);
            check("R9 pin_o intact", {24'h0, pin_out}, {24'h0, s_dout});
            check("R9 pin_oe intact", {24'h0, pin_oe}, {24'h0, s_dir});
        end

        // R4 R5 R6 R7 R10: sweep every pin pattern under several configurations
        for (int c = 0; c < 4; c++) begin
            set_cfg(cd[c], cp[c], ci[c], cw[c]);
            wake_en = ce[c];
            for (int p = 0; p < 256; p++) begin
                logic [7:0] adj;
                logic       e_irq_n, e_wake;
                @(negedge clk);
                pin_in = p[7:0];
                repeat (3) @(posedge clk);
                @(negedge clk);
                adj = p[7:0] ^ s_pol;
                e_irq_n = ~|(adj & s_imask & ~s_dir);
                e_wake = ce[c] & (|(adj & s_wmask & ~s_dir));
                read_check("R4 R5 status", 8'h07, adj);
                check("R6 R10 irq_n", {31'h0, irq_n}, {31'h0, e_irq_n});
                check("R7 R10 wake_oe", {31'h0, wake_oe}, {31'h0, e_wake});
                check("R7 wake value", {31'h0, wake_val}, 32'h0);
            end
        end

        // R7: dropping wake enable removes the request one edge later
        set_cfg(8'h00, 8'h00, 8'h00, 8'h01);
        wake_en = 1'b1;
        @(negedge clk); pin_in = 8'h01;
        repeat (4) @(negedge clk);
        check("R7 wake active", {31'h0, wake_oe}, 32'h1);
        check("R6 no imask irq idle", {31'h0, irq_n}, 32'h1);
        wake_en = 1'b0;
        @(negedge clk);
        check("R7 wake gated", {31'h0, wake_oe}, 32'h0);

        // R10: switching the source line to output silences it
        wake_en = 1'b1;
        do_write(8'h05, 8'h01);
        @(negedge clk);
        check("R6 irq active", {31'h0, irq_n}, 32'h0);
        do_write(8'h02, 8'h01);
        @(negedge clk);
        check("R10 irq silent", {31'h0, irq_n}, 32'h1);
        check("R10 wake silent", {31'h0, wake_oe}, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule